// File: doc/BRIEF.md
# Two-Phase Current-Sharing Duty Combiner

This block produces the duty command for each of two interleaved converter phases. A single voltage-loop compensator, outside the block, supplies one common duty word. Each phase has its own current-sharing corrector. That corrector compares the phase's current sample with a shared reference and produces a signed correction. The correction is added to the common duty for that phase alone. The two loops therefore act side by side, and both shape every duty value that reaches the modulators.

Current samples enter as a valid/ready stream. One beat carries both phase currents. The block never applies back-pressure after reset: `smp_ready` is low while reset is held, rises on the first clock edge after reset is released, and then stays high. A beat is taken when `smp_valid` and `smp_ready` are both high. The duty outputs are plain control words with no handshake. They hold their value until the next register update, and the modulators may read them at any time.

The shared reference is either the mean of the two currents or the larger of the two. Each correction combines a proportional term and an integral term, both scaled by right shifts. The integrator has a clamp that prevents windup, and the final correction is limited to a magnitude set at a port. Each duty is kept below half the switching period. When sharing is off, all correction state is cleared and both phases follow the common duty.

Top module: `share_duty_combiner`

## Requirements
- R1: While `rst` is high, `duty_a`, `duty_b` and `smp_ready` are all 0.
- R2: With `ref_sel` = 0 the reference is floor((cur_a + cur_b) / 2).
- R3: With `ref_sel` = 1 the reference is the larger of `cur_a` and `cur_b`.
- R4: For each phase, err = reference − phase current. The correction is (err >>> KP_SH) + (integ >>> KI_SH), where integ is the integrator value after the current beat. Both shifts are arithmetic. The defaults are KP_SH = 1 and KI_SH = 4.
- R5: On each accepted beat, the integrator adds err and is clamped to ±INT_LIM (default 4000).
- R6: The correction is saturated to ±`corr_lim` before it is added.
- R7: duty = `duty_cmd` + correction, clamped to the range 0 to 2^(DW−1)−1 (511 by default). The result appears on the clock edge that follows the inputs.
- R8: While `share_en` is 0, the integrators and corrections are zero and sample beats have no effect. Each duty equals the clamped `duty_cmd` one edge later. This applies even on the edge where `share_en` falls together with a beat.
- R9: Corrections change only on accepted beats. Between beats, a change of `duty_cmd` reaches both duties one edge later, with the held corrections.
- R10: `smp_ready` becomes 1 on the first edge after reset is released and then stays at 1. A beat counts only when `smp_valid` and `smp_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| share_en | input | 1 | Enables current sharing; 0 clears all correction state |
| ref_sel | input | 1 | Share reference: 0 = average, 1 = highest current |
| corr_lim | input | CW-1 | Magnitude limit for each correction |
| duty_cmd | input | DW | Common duty from the voltage compensator |
| smp_valid | input | 1 | Current-sample beat valid |
| smp_ready | output | 1 | Block accepts a beat |
| smp_cur_a | input | IW | Phase A current sample |
| smp_cur_b | input | IW | Phase B current sample |
| duty_a | output | DW | Phase A duty command |
| duty_b | output | DW | Phase B duty command |

## Verification
A sample beat can arrive on the same edge where sharing is switched off. Only the clearing may take effect: the bench drives that beat with a large imbalance and expects both duties to equal the clamped common duty one edge later. A second collision occurs when the integrator reaches its clamp, the correction reaches `corr_lim` and the duty hits its ceiling or floor, all on one beat. Long runs of one-sided imbalance with a small limit and common duties near both rails provoke this. Each edge is compared with a reference model built from the requirements.

// File: rtl/share_pkg.sv
package share_pkg;
  localparam int NPH = 2;

  typedef enum logic {
    REF_AVG  = 1'b0,
    REF_PEAK = 1'b1
  } ref_mode_e;
endpackage

// File: rtl/share_ref.sv
module share_ref import share_pkg::*; #(
  parameter int IW = 10
) (
  input  logic [NPH-1:0][IW-1:0] cur_i,
  input  ref_mode_e              mode_i,
  output logic [IW-1:0]          ref_o
);
  localparam int SH = $clog2(NPH);
  localparam int SW = IW + SH;

  logic [SW-1:0] sum;
  logic [IW-1:0] peak;
  logic [IW-1:0] avg;

  always_comb begin
    sum  = '0;
    peak = '0;
    for (int k = 0; k < NPH; k++) begin
      sum = sum + SW'(cur_i[k]);
      if (cur_i[k] > peak) peak = cur_i[k];
    end
    avg   = IW'(sum >> SH);
    ref_o = (mode_i == REF_PEAK) ? peak : avg;
  end
endmodule

// File: rtl/share_pi.sv
module share_pi #(
  parameter int IW      = 10,
  parameter int CW      = 10,
  parameter int INT_W   = 16,
  parameter int INT_LIM = 4000,
  parameter int KP_SH   = 1,
  parameter int KI_SH   = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic                 take_i,
  input  logic [IW-1:0]        ref_i,
  input  logic [IW-1:0]        cur_i,
  input  logic [CW-2:0]        lim_i,
  output logic signed [CW-1:0] corr_o
);
  localparam int EW = IW + 1;
  localparam int SW = INT_W + 2;
  localparam logic signed [INT_W-1:0] ILIM = INT_W'(INT_LIM);

  logic signed [EW-1:0]    err;
  logic signed [INT_W:0]   integ_sum;
  logic signed [INT_W-1:0] integ_q, integ_nxt;
  logic signed [SW-1:0]    p_term, i_term, pi_sum, lim_s, pi_c;
  logic signed [CW-1:0]    corr_q, corr_nxt;
  logic signed [CW-1:0]    lim_pos;

  always_comb begin
    err       = $signed({1'b0, ref_i}) - $signed({1'b0, cur_i});
    integ_sum = (INT_W+1)'(integ_q) + (INT_W+1)'(err);
    if (integ_sum > (INT_W+1)'(ILIM))
      integ_nxt = ILIM;
    else if (integ_sum < -((INT_W+1)'(ILIM)))
      integ_nxt = -ILIM;
    else
      integ_nxt = INT_W'(integ_sum);

    p_term = SW'(err) >>> KP_SH;
    i_term = SW'(integ_nxt) >>> KI_SH;
    pi_sum = p_term + i_term;
    lim_s  = $signed(SW'(lim_i));
    if (pi_sum > lim_s)       pi_c = lim_s;
    else if (pi_sum < -lim_s) pi_c = -lim_s;
    else                      pi_c = pi_sum;
    corr_nxt = CW'(pi_c);

    if (!en_i)       corr_o = '0;
    else if (take_i) corr_o = corr_nxt;
    else             corr_o = corr_q;

    lim_pos = $signed({1'b0, lim_i});
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      integ_q <= '0;
      corr_q  <= '0;
    end else if (take_i) begin
      integ_q <= integ_nxt;
      corr_q  <= corr_nxt;
    end
  end

  // R5: anti-windup keeps the integrator inside its band
  a_r5_integ_bound: assert property (@(posedge clk) disable iff (rst)
    (integ_q <= ILIM) && (integ_q >= -ILIM));

  // R8: disabling clears all correction state
  a_r8_clear_off: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (integ_q == '0) && (corr_q == '0));

  // R9: no beat, no change of stored correction
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (en_i && !take_i) |=> $stable(corr_q) && $stable(integ_q));

  // R6: stored correction respects the limit seen on its beat
  a_r6_corr_limit: assert property (@(posedge clk) disable iff (rst)
    (en_i && take_i) |=> (corr_q <= $past(lim_pos)) && (corr_q >= -$past(lim_pos)));
endmodule

// File: rtl/duty_sum.sv
module duty_sum #(
  parameter int DW = 10,
  parameter int CW = 10
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        cmd_i,
  input  logic signed [CW-1:0] corr_i,
  output logic [DW-1:0]        duty_o
);
  localparam int SW = ((DW > CW) ? DW : CW) + 2;
  localparam logic [DW-1:0] DMAX = {1'b0, {(DW-1){1'b1}}};

  logic signed [SW-1:0] sum;
  logic [DW-1:0]        duty_nxt;

  always_comb begin
    sum = $signed(SW'(cmd_i)) + SW'(corr_i);
    if (sum < 0)                       duty_nxt = '0;
    else if (sum > $signed(SW'(DMAX))) duty_nxt = DMAX;
    else                               duty_nxt = DW'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) duty_o <= '0;
    else     duty_o <= duty_nxt;
  end

  // R7: duty never reaches half the period
  a_r7_duty_ceiling: assert property (@(posedge clk) disable iff (rst)
    duty_o <= DMAX);
endmodule

// File: rtl/share_duty_combiner.sv
module share_duty_combiner import share_pkg::*; #(
  parameter int IW      = 10,
  parameter int DW      = 10,
  parameter int CW      = 10,
  parameter int INT_W   = 16,
  parameter int INT_LIM = 4000,
  parameter int KP_SH   = 1,
  parameter int KI_SH   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          share_en,
  input  logic          ref_sel,
  input  logic [CW-2:0] corr_lim,
  input  logic [DW-1:0] duty_cmd,
  input  logic          smp_valid,
  output logic          smp_ready,
  input  logic [IW-1:0] smp_cur_a,
  input  logic [IW-1:0] smp_cur_b,
  output logic [DW-1:0] duty_a,
  output logic [DW-1:0] duty_b
);
  logic [NPH-1:0][IW-1:0] cur;
  logic [IW-1:0]          share_ref_val;
  logic [NPH-1:0][DW-1:0] duty;
  logic                   rdy_q;
  logic                   take;

  assign cur[0]    = smp_cur_a;
  assign cur[1]    = smp_cur_b;
  assign smp_ready = rdy_q;
  assign take      = smp_valid && rdy_q;
  assign duty_a    = duty[0];
  assign duty_b    = duty[1];

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  share_ref #(.IW(IW)) u_ref (
    .cur_i  (cur),
    .mode_i (ref_mode_e'(ref_sel)),
    .ref_o  (share_ref_val)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    logic signed [CW-1:0] corr;

    share_pi #(
      .IW(IW), .CW(CW), .INT_W(INT_W), .INT_LIM(INT_LIM),
      .KP_SH(KP_SH), .KI_SH(KI_SH)
    ) u_pi (
      .clk    (clk),
      .rst    (rst),
      .en_i   (share_en),
      .take_i (take),
      .ref_i  (share_ref_val),
      .cur_i  (cur[p]),
      .lim_i  (corr_lim),
      .corr_o (corr)
    );

    duty_sum #(.DW(DW), .CW(CW)) u_sum (
      .clk    (clk),
      .rst    (rst),
      .cmd_i  (duty_cmd),
      .corr_i (corr),
      .duty_o (duty[p])
    );
  end

  // R8: with sharing off both phases follow the same command
  a_r8_equal_when_off: assert property (@(posedge clk) disable iff (rst)
    !share_en |=> (duty_a == duty_b));

  // R10: ready never drops once raised
  a_r10_ready_stays: assert property (@(posedge clk) disable iff (rst)
    smp_ready |=> smp_ready);
endmodule

// File: tb/test_share_duty_combiner.sv
module test_share_duty_combiner;
  localparam int ILIM = 4000;
  localparam int KP   = 1;
  localparam int KI   = 4;
  localparam int DMAX = 511;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       share_en = 1'b0;
  logic       ref_sel = 1'b0;
  logic [8:0] corr_lim = '0;
  logic [9:0] duty_cmd = '0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic [9:0] smp_cur_a = '0;
  logic [9:0] smp_cur_b = '0;
  logic [9:0] duty_a, duty_b;

  typedef struct { int da; int db; int req; } exp_t;
  exp_t q[$];

  int checks = 0;
  int failures = 0;
  int ig[2];
  int cr[2];
  bit done = 0;

  always #4 clk = ~clk;

  share_duty_combiner i_share_duty_combiner (
    .clk(clk), .rst(rst), .share_en(share_en), .ref_sel(ref_sel),
    .corr_lim(corr_lim), .duty_cmd(duty_cmd), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_cur_a(smp_cur_a), .smp_cur_b(smp_cur_b),
    .duty_a(duty_a), .duty_b(duty_b)
  );

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected duties
  task automatic step(bit en, bit sel, int lim, int cmd, bit v, int a, int b, int req);
    int rf, corr[2], cur[2], err, p, i;
    exp_t e;
    @(negedge clk);
    share_en = en; ref_sel = sel; corr_lim = 9'(lim); duty_cmd = 10'(cmd);
    smp_valid = v; smp_cur_a = 10'(a); smp_cur_b = 10'(b);
    cur[0] = a; cur[1] = b;
    rf = sel ? ((a > b) ? a : b) : (a + b) / 2;
    for (int k = 0; k < 2; k++) begin
      if (!en) begin
        ig[k] = 0; cr[k] = 0; corr[k] = 0;
      end else if (v) begin
        err = rf - cur[k];
        ig[k] = clampi(ig[k] + err, -ILIM, ILIM);
        p = err >>> KP;
        i = ig[k] >>> KI;
        cr[k] = clampi(p + i, -lim, lim);
        corr[k] = cr[k];
      end else begin
        corr[k] = cr[k];
      end
    end
    e.da = clampi(cmd + corr[0], 0, DMAX);
    e.db = clampi(cmd + corr[1], 0, DMAX);
    e.req = req;
    q.push_back(e);
  endtask

  // monitor: compares registered duties after each edge
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      string tag;
      e = q.pop_front();
      tag = $sformatf("R%0d", e.req);
      chk({tag, " duty_a"}, int'(duty_a), e.da);
      chk({tag, " duty_b"}, int'(duty_b), e.db);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #800000;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    ig[0] = 0; ig[1] = 0; cr[0] = 0; cr[1] = 0;
    duty_cmd = 10'd300;
    repeat (3) @(posedge clk);
    #2;
    // R1 reset state
    chk("R1 duty_a in reset", int'(duty_a), 0);
    chk("R1 duty_b in reset", int'(duty_b), 0);
    chk("R1 ready in reset", int'(smp_ready), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #2;
    chk("R10 ready after reset", int'(smp_ready), 1);

    // R8: disabled, beats ignored, duties follow common command
    step(0, 0, 200, 300, 1, 0, 1000, 8);
    step(0, 1, 200, 450, 1, 900, 5, 8);
    step(0, 0, 200, 600, 0, 0, 0, 8);

    // R4: single hand-computed beat, average reference (R2)
    step(1, 0, 500, 200, 1, 100, 300, 4);
    @(posedge clk); #3;
    chk("R4 duty_a hand value", int'(duty_a), 256);
    chk("R4 duty_b hand value", int'(duty_b), 143);

    // R2: more average-reference beats
    step(1, 0, 500, 200, 1, 120, 280, 2);
    step(1, 0, 500, 200, 1, 201, 200, 2);

    // R9: no beats, common command moves, corrections hold
    step(1, 0, 500, 250, 0, 0, 1000, 9);
    step(1, 0, 500, 100, 0, 1000, 0, 9);
    step(1, 0, 500, 320, 1, 180, 220, 9);

    // R10: valid low with garbage currents does nothing
    step(1, 0, 500, 320, 0, 1023, 0, 10);

    // R3: peak reference
    step(0, 1, 500, 300, 0, 0, 0, 8);
    step(1, 1, 500, 300, 1, 400, 250, 3);
    step(1, 1, 500, 300, 1, 250, 400, 3);
    step(1, 1, 500, 300, 1, 333, 333, 3);

    // R5: long one-sided imbalance saturates integrator, then reverse
    for (int n = 0; n < 14; n++) step(1, 0, 511, 256, 1, 0, 1000, 5);
    for (int n = 0; n < 6; n++) step(1, 0, 511, 256, 1, 1000, 0, 5);

    // R6: small limit clamps both corrections
    for (int n = 0; n < 4; n++) step(1, 1, 20, 256, 1, 100, 700, 6);
    step(1, 1, 3, 256, 1, 700, 100, 6);

    // R7: rails on both ends
    step(1, 0, 511, 500, 1, 0, 1000, 7);
    step(1, 0, 511, 5, 1, 0, 1000, 7);
    step(1, 0, 511, 1023, 0, 0, 0, 7);

    // R8: beat on the same edge sharing turns off
    step(0, 0, 511, 200, 1, 0, 1000, 8);
    step(1, 0, 511, 200, 0, 0, 0, 8);

    @(negedge clk); smp_valid = 1'b0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule